// File: doc/BRIEF.md
# Counting Histogram with One-Cycle Clear

This block keeps a histogram of incoming keys in on-chip memory. Each cycle a key may arrive with a valid strobe. The key addresses a count memory, and the addressed bin is read, incremented and written back. A second memory, addressed by the same key, holds for every bin the epoch number in which the bin was last written. A global epoch register gives the current epoch. A bin whose stored epoch differs from the current one counts as empty. Emptying the whole histogram is therefore one clear pulse that advances the epoch, and the count memory is never rewritten.

A separate read port returns the effective count of a requested bin after a fixed latency. The epoch register is narrow. When a clear would wrap it back onto values that stale tags may still hold, the block scrubs the tag memory to zero in the background and raises busy. The same scrub runs after reset, so memories with unknown contents start out as an empty histogram.

Top module: `hist_fast_clear`

## Requirements
- R1: When `in_valid` is high and `busy` is low, the bin addressed by `in_key` grows by one. A read issued in any later cycle returns the new count.
- R2: Increments to the same bin in consecutive cycles are all counted. A read issued in the cycle after the last increment already includes it.
- R3: A count stops at 2^CNT_W-1 (255 by default) and never wraps to zero.
- R4: A `clear` pulse with `busy` low empties every bin within one cycle. A read issued in the clear cycle or later returns 0 for bins not incremented since. An increment presented in the clear cycle or later counts in the new histogram.
- R5: A read request in cycle t gives `rd_valid` high for exactly one cycle, in cycle t+2, with the count in `rd_count`.
- R6: After reset `busy` is high for exactly 2^KEY_W cycles (64 by default) and all bins read 0. While `busy` is high, `in_valid` and `clear` are ignored.
- R7: The epoch starts at 1 and each accepted clear adds one. When a clear arrives at epoch 2^TAG_W-1 (7 by default), the epoch returns to 1 and a 2^KEY_W-cycle scrub starts with `busy` high. The increment presented in that same cycle is discarded. Afterwards every bin reads 0.
- R8: A read whose count is formed while `busy` is high returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | One-cycle histogram clear (advances the epoch) |
| in_valid | input | 1 | Key strobe |
| in_key | input | KEY_W | Bin to increment |
| rd_req | input | 1 | Read request |
| rd_key | input | KEY_W | Bin to read |
| rd_valid | output | 1 | Read result valid, two cycles after `rd_req` |
| rd_count | output | CNT_W | Effective count of the requested bin |
| busy | output | 1 | Tag scrub in progress |

## Verification
The hardest case to reach from the ports is an epoch wrap that coincides with pipeline traffic. In that case a clear lands on the last epoch value while an increment is in flight and another is presented in the same cycle. The directed part issues clears back to back until the epoch reaches its last value, with an increment and a read on the clear cycle. It then checks `busy` for its full length and checks that the bin is empty after the scrub. The random part uses a small key range and frequent clears, so forwarding collisions, clears against pending writes and several wraps all occur against the bench's reference model.

// File: rtl/hfc_pkg.sv
// Shared definitions for the fast-clear histogram.
// Assumes: epoch numbering starts at one; zero is the scrubbed tag value.
package hfc_pkg;
    typedef enum logic {EP_RUN = 1'b0, EP_SCRUB = 1'b1} epoch_state_e;
    localparam int unsigned EPOCH_FIRST = 1;
endpackage

// File: rtl/hfc_ram.sv
// Simple memory with one write port and two registered read ports.
// A read to the address being written in the same cycle returns the new data
// (write-through forwarding), so back-to-back read-modify-writes stay exact.
// Assumes: contents are undefined at power-up; the user masks them by tag.
module hfc_ram #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port A with forwarding from a same-cycle write.
    always_ff @(posedge clk) begin
        rdata_a <= (we && (waddr == raddr_a)) ? wdata : mem[raddr_a];
    end

    // Read port B with forwarding from a same-cycle write.
    always_ff @(posedge clk) begin
        rdata_b <= (we && (waddr == raddr_b)) ? wdata : mem[raddr_b];
    end
endmodule

// File: rtl/hfc_epoch.sv
// Epoch register and tag scrub sequencer.
// Holds the current epoch; a clear advances it. On reset, or on a clear at the
// last epoch value, it walks every bin once so the tag memory can be zeroed,
// reporting busy for exactly 2^KEY_W cycles.
// Assumes: clear is ignored while scrubbing.
module hfc_epoch #(
    parameter int unsigned KEY_W = 6,
    parameter int unsigned TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic             busy,
    output logic [TAG_W-1:0] epoch,
    output logic [KEY_W-1:0] scrub_idx
);
    import hfc_pkg::*;

    localparam logic [TAG_W-1:0] EPOCH_LAST  = {TAG_W{1'b1}};
    localparam logic [TAG_W-1:0] EPOCH_START = TAG_W'(EPOCH_FIRST);
    localparam logic [KEY_W-1:0] IDX_LAST    = {KEY_W{1'b1}};

    epoch_state_e state;

    assign busy = (state == EP_SCRUB);

    // Epoch advance and scrub walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= EP_SCRUB;
            scrub_idx <= '0;
            epoch     <= EPOCH_START;
        end else begin
            case (state)
                EP_SCRUB: begin
                    scrub_idx <= scrub_idx + 1'b1;
                    if (scrub_idx == IDX_LAST) state <= EP_RUN;
                end
                default: begin
                    if (clear) begin
                        if (epoch == EPOCH_LAST) begin
                            epoch     <= EPOCH_START;
                            scrub_idx <= '0;
                            state     <= EP_SCRUB;
                        end else begin
                            epoch <= epoch + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hist_fast_clear.sv
// Histogram of incoming keys with a one-cycle clear.
// Stage 1 registers the key while both memories are read; stage 2 masks the
// count by tag, increments with saturation and writes count and epoch back.
// Reads use the second memory ports and return the masked count two cycles later.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
module hist_fast_clear #(
    parameter int unsigned KEY_W = 6,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             in_valid,
    input  logic [KEY_W-1:0] in_key,
    input  logic             rd_req,
    input  logic [KEY_W-1:0] rd_key,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_count,
    output logic             busy
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [TAG_W-1:0] epoch;
    logic [KEY_W-1:0] scrub_idx;

    logic             s1_v;
    logic [KEY_W-1:0] s1_key;
    logic [CNT_W-1:0] inc_cnt_q, rd_cnt_q;
    logic [TAG_W-1:0] inc_tag_q, rd_tag_q;

    logic [CNT_W-1:0] cur_cnt, wr_cnt;
    logic             inc_we;
    logic             tag_we;
    logic [KEY_W-1:0] tag_waddr;
    logic [TAG_W-1:0] tag_wdata;
    logic             r1_v;

    hfc_epoch #(.KEY_W(KEY_W), .TAG_W(TAG_W)) u_epoch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .busy      (busy),
        .epoch     (epoch),
        .scrub_idx (scrub_idx)
    );

    hfc_ram #(.DW(CNT_W), .AW(KEY_W)) u_cnt_ram (
        .clk     (clk),
        .we      (inc_we),
        .waddr   (s1_key),
        .wdata   (wr_cnt),
        .raddr_a (in_key),
        .rdata_a (inc_cnt_q),
        .raddr_b (rd_key),
        .rdata_b (rd_cnt_q)
    );

    hfc_ram #(.DW(TAG_W), .AW(KEY_W)) u_tag_ram (
        .clk     (clk),
        .we      (tag_we),
        .waddr   (tag_waddr),
        .wdata   (tag_wdata),
        .raddr_a (in_key),
        .rdata_a (inc_tag_q),
        .raddr_b (rd_key),
        .rdata_b (rd_tag_q)
    );

    // Stage 2: tag-masked count, saturating increment, write steering.
    always_comb begin
        cur_cnt   = (inc_tag_q == epoch) ? inc_cnt_q : '0;
        wr_cnt    = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + 1'b1;
        inc_we    = s1_v && !busy;
        tag_we    = inc_we || busy;
        tag_waddr = busy ? scrub_idx : s1_key;
        tag_wdata = busy ? '0 : epoch;
    end

    // Stage 1: accept a key unless a scrub is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_key <= '0;
        end else begin
            s1_v   <= in_valid && !busy;
            s1_key <= in_key;
        end
    end

    // Readout: mask the read data by tag and scrub state, fixed two-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_v     <= 1'b0;
            rd_valid <= 1'b0;
            rd_count <= '0;
        end else begin
            r1_v     <= rd_req;
            rd_valid <= r1_v;
            rd_count <= (!busy && (rd_tag_q == epoch)) ? rd_cnt_q : '0;
        end
    end
endmodule

// File: rtl/hfc_checker.sv
// Property checker for hist_fast_clear, attached by bind.
// Assumes: synchronous active-low reset; all signals sampled on posedge clk.
module hfc_checker #(
    parameter int unsigned KEY_W = 6,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             rd_req,
    input logic             rd_valid,
    input logic [CNT_W-1:0] rd_count,
    input logic             busy,
    input logic [TAG_W-1:0] epoch,
    input logic             inc_we,
    input logic [CNT_W-1:0] wr_cnt
);
    localparam int unsigned     BINS       = 1 << KEY_W;
    localparam logic [TAG_W-1:0] EPOCH_LAST = {TAG_W{1'b1}};

    logic [KEY_W:0] busy_len;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inc_we |-> (wr_cnt != '0));

    assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ##1 rd_valid);

    assert_read_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req, 2));

    assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == (KEY_W+1)'(BINS)));

    assert_no_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !inc_we);

    assert_epoch_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear && !busy) && !busy) |-> (epoch == TAG_W'($past(epoch) + 1'b1)));

    assert_epoch_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear && !busy && (epoch == EPOCH_LAST)) |-> (busy && (epoch == TAG_W'(1))));

    assert_busy_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy)) |-> (rd_count == '0));
endmodule

bind hist_fast_clear hfc_checker #(.KEY_W(KEY_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_hfc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_count (rd_count),
    .busy     (busy),
    .epoch    (epoch),
    .inc_we   (inc_we),
    .wr_cnt   (wr_cnt)
);

// File: tb/test_hist_fast_clear.sv
`timescale 1ns/1ps
// Bench: directed corner cases and seeded random traffic against a
// cycle-level reference model of the histogram.
module test_hist_fast_clear;
    localparam int unsigned KEY_W = 6;
    localparam int unsigned CNT_W = 8;
    localparam int unsigned TAG_W = 3;
    localparam int BINS      = 1 << KEY_W;
    localparam int CNT_MAX   = (1 << CNT_W) - 1;
    localparam int EPOCH_MAX = (1 << TAG_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clear = 1'b0;
    logic             in_valid = 1'b0;
    logic [KEY_W-1:0] in_key = '0;
    logic             rd_req = 1'b0;
    logic [KEY_W-1:0] rd_key = '0;
    logic             rd_valid;
    logic [CNT_W-1:0] rd_count;
    logic             busy;

    hist_fast_clear #(.KEY_W(KEY_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) i_hist_fast_clear (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .in_key(in_key),
        .rd_req(rd_req), .rd_key(rd_key), .rd_valid(rd_valid), .rd_count(rd_count), .busy(busy)
    );

    always #2.5 clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    model [BINS];
    int    epoch_m;
    int    busy_left;
    bit    e1_v, e2_v;
    int    e1_c, e2_c;
    string e1_tag, e2_tag;

    function automatic int sat_inc(input int v);
        return (v >= CNT_MAX) ? CNT_MAX : v + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_zero();
        for (int i = 0; i < BINS; i++) model[i] = 0;
    endtask

    // One cycle: check outputs, drive inputs, advance the model.
    task automatic step(input bit cl, input bit iv, input int ik,
                        input bit rr, input int rk, input string tag);
        bit busy_now;
        bit wrapped;
        @(negedge clk);
        check("R5", int'(rd_valid), int'(e2_v));
        if (e2_v) check(e2_tag, int'(rd_count), e2_c);
        busy_now = (busy_left > 0);
        check("R6", int'(busy), int'(busy_now));
        clear    = cl;
        in_valid = iv;
        in_key   = KEY_W'(ik);
        rd_req   = rr;
        rd_key   = KEY_W'(rk);
        wrapped  = 1'b0;
        if (busy_now) begin
            busy_left--;
        end else if (cl) begin
            model_zero();
            if (epoch_m == EPOCH_MAX) begin
                epoch_m   = 1;
                busy_left = BINS;
                wrapped   = 1'b1;
            end else begin
                epoch_m++;
            end
        end
        e2_v = e1_v; e2_c = e1_c; e2_tag = e1_tag;
        e1_v = rr;   e1_c = rr ? model[rk] : 0; e1_tag = tag;
        if (iv && !busy_now && !wrapped) model[ik] = sat_inc(model[ik]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "R1");
    endtask

    task automatic wait_ready();
        while (busy_left > 0) step(0, 0, 0, 0, 0, "R6");
    endtask

    task automatic rd(input int k, input string tag);
        step(0, 0, 0, 1, k, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clear = 0; in_valid = 0; rd_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_zero();
        epoch_m   = 1;
        busy_left = BINS - 1;   // first post-reset cycle is already under way
        e1_v = 0; e2_v = 0; e1_c = 0; e2_c = 0; e1_tag = "R5"; e2_tag = "R5";
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        do_reset();
        // R6 / R8: reset state, reads and increments during the startup scrub.
        check("R6", int'(busy), 1);
        check("R5", int'(rd_valid), 0);
        rd(5, "R8");
        step(0, 1, 5, 0, 0, "R6");
        step(1, 1, 5, 1, 7, "R8");
        wait_ready();
        rd(5, "R6");
        rd(0, "R6");
        idle(2);
        check("R7", epoch_m, 1);
        // R1: spaced increments on several bins.
        step(0, 1, 3, 0, 0, "R1"); idle(1);
        step(0, 1, 3, 0, 0, "R1"); idle(1);
        step(0, 1, 40, 0, 0, "R1");
        idle(3);
        rd(3, "R1"); rd(40, "R1"); rd(63, "R1");
        // R2: back-to-back same bin, then read in the next cycle.
        for (int i = 0; i < 4; i++) step(0, 1, 9, 0, 0, "R2");
        rd(9, "R2");
        step(0, 1, 9, 0, 0, "R2");
        step(0, 0, 0, 1, 9, "R2");
        // R3: saturation.
        for (int i = 0; i < CNT_MAX + 40; i++) step(0, 1, 20, 0, 0, "R3");
        idle(2);
        rd(20, "R3");
        step(0, 1, 20, 0, 0, "R3");
        idle(2);
        rd(20, "R3");
        // R4: clear in one cycle; increment and read in the clear cycle.
        step(0, 1, 3, 0, 0, "R4");
        step(1, 1, 3, 1, 3, "R4");
        rd(3, "R4"); rd(20, "R4"); rd(9, "R4");
        // R7: walk the epoch to its last value and wrap with traffic.
        while (epoch_m < EPOCH_MAX) step(1, 0, 0, 0, 0, "R7");
        step(0, 1, 11, 0, 0, "R7");
        step(0, 1, 12, 0, 0, "R7");
        step(1, 1, 12, 1, 11, "R7");
        step(0, 1, 13, 1, 12, "R8");
        wait_ready();
        rd(11, "R7"); rd(12, "R7"); rd(13, "R7");
        idle(2);
        check("R7", epoch_m, 1);
        // Random traffic on a narrow key range with frequent clears.
        for (int i = 0; i < 6000; i++) begin
            bit cl, iv, rr;
            int ik, rk;
            cl = ($urandom % 40) == 0;
            iv = ($urandom % 4) != 0;
            rr = ($urandom % 3) == 0;
            ik = $urandom % 6;
            rk = (($urandom % 4) == 0) ? ($urandom % BINS) : ($urandom % 6);
            step(cl, iv, ik, rr, rk, "R1");
        end
        idle(3);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule